// File: doc/BRIEF.md
# Auto-Indexed Two-Part Lookup Table Port

This block holds a 384-entry lookup table in which every entry is made of two parts: a wide upper part and a 12-bit lower part. Software reaches the table through a four-word register window and never supplies an entry address. An internal index chooses the entry and moves forward by itself. To load an entry, software first writes the upper part, which waits in a holding register. It then writes the lower part, which stores both halves at the current index and advances the index. A control bit carried in the lower-part write moves the index back to entry 0, so software can start a fresh load.

A read-back mode starts when software writes a control word to the lower-part register. In this mode, software reads the upper part of each entry and then its lower part, and the index advances once per entry. The same window also holds a scalar threshold register and an operating-mode word. That word carries three enable outputs, for hue, saturation and value adjustment. A separate read-only lookup port lets a pixel datapath fetch any entry by index, with one clock of latency.

Top module: `paired_lut_port`

## Requirements
- R1: After synchronous reset, the threshold register and the operating-mode register read as zero. The hue, saturation and value enable outputs are low, and a read at byte offset 0 or 4 returns zero.
- R2: A write at byte offset 4 stores a 32-bit upper part in a holding register. A later write at offset 0 stores {held upper part, lower part} into the entry at the current index and then adds one to the index. The lookup port then returns that entry.
- R3: Only bits 11:0 of an offset-0 write are kept as the lower part. In read-back mode, reads of the lower part return it zero-extended above bit 11.
- R4: An offset-0 write with bit 26 set and bit 25 clear sets the index to 0 before the store. The entry therefore lands at entry 0, and the next write goes to entry 1.
- R5: The index goes from 383 back to 0, both after a store and after a read-back step.
- R6: An offset-0 write with bits 25 and 26 both set stores nothing. It enters read-back mode and sets the index to 0. In read-back mode, a read at offset 4 returns the upper part of the current entry. A read at offset 0 returns the lower part and then adds one to the index. Read data appears on the cycle after the read strobe.
- R7: Any other offset-0 write leaves read-back mode. Outside read-back mode, reads at offsets 0 and 4 return zero and do not move the index.
- R8: Byte offset 8 is a 32-bit threshold register that reads back exactly what was last written.
- R9: Byte offset 12 is the operating-mode word. Bit 29 drives the hue enable, bit 30 the saturation enable and bit 31 the value enable. A read returns those three bits in place, with all other bits zero.
- R10: The lookup port returns {upper, lower} of the indexed entry one clock after the index is presented. An index of 384 or more returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_rd | input | 1 | Read strobe for the register window |
| bus_addr | input | 4 | Byte offset inside the window (0, 4, 8 or 12) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| lk_idx | input | 9 | Entry index for the datapath lookup |
| lk_data | output | 44 | {upper, lower} of the indexed entry, one cycle later |
| hue_en | output | 1 | Hue adjustment enable |
| sat_en | output | 1 | Saturation adjustment enable |
| val_en | output | 1 | Value adjustment enable |

## Verification
The hardest case to reach is an index wrap that happens with no explicit reset in between. The bench first advances the index to a non-zero position with a few throwaway stores. It then reloads the table starting from an index-reset write, walks the whole read-back sequence past entry 383, and performs one store beyond the end of the table. The wrapped read and the overwritten entry 0 are checked through the lookup port, using values computed from the entry number.

// File: rtl/lut_pkg.sv
package lut_pkg;
  parameter int LUT_DEPTH   = 384;
  parameter int LUT_IDX_W   = $clog2(LUT_DEPTH);
  parameter int LUT_HI_W    = 32;
  parameter int LUT_LO_W    = 12;
  parameter int LUT_ENT_W   = LUT_HI_W + LUT_LO_W;
  parameter int BUS_W       = 32;
  parameter int BUS_AW      = 4;

  // control bits carried by a lower-part write
  parameter int CTL_IDX_CLR = 26;
  parameter int CTL_RD_MODE = 25;
  // enable bit positions in the operating-mode word
  parameter int EN_HUE_BIT  = 29;
  parameter int EN_SAT_BIT  = 30;
  parameter int EN_VAL_BIT  = 31;

  typedef enum logic [1:0] {
    WIN_LO   = 2'd0,
    WIN_HI   = 2'd1,
    WIN_THR  = 2'd2,
    WIN_MODE = 2'd3
  } win_sel_e;
endpackage

// File: rtl/lut_mem.sv
module lut_mem #(
  parameter int DEPTH = 384,
  parameter int IDX_W = 9,
  parameter int W     = 44
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ra_addr,
  output logic [W-1:0]     ra_data,
  input  logic [IDX_W-1:0] lk_addr,
  output logic [W-1:0]     lk_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [W-1:0]     ra_q;
  logic [W-1:0]     lk_q;
  logic             lk_ok_q;
  logic             lk_ok;
  logic [IDX_W-1:0] lk_safe;

  assign lk_ok   = (lk_addr <= LAST);
  assign lk_safe = lk_ok ? lk_addr : '0;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_q <= mem[ra_addr];
    lk_q <= mem[lk_safe];
  end

  always_ff @(posedge clk) begin
    if (rst) lk_ok_q <= 1'b0;
    else     lk_ok_q <= lk_ok;
  end

  assign ra_data = ra_q;
  assign lk_data = lk_ok_q ? lk_q : '0;

  AST_LOOKUP_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (lk_addr > LAST) |=> (lk_data == '0)); // R10
endmodule

// File: rtl/lut_seq.sv
module lut_seq #(
  parameter int DEPTH = 384,
  parameter int IDX_W = 9,
  parameter int HI_W  = 32,
  parameter int LO_W  = 12,
  parameter int BW    = 32,
  parameter int CLR_B = 26,
  parameter int RDM_B = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic                 rd_lo,
  input  logic [BW-1:0]        wdata,
  output logic [IDX_W-1:0]     idx,
  output logic                 rd_mode,
  output logic                 mem_we,
  output logic [IDX_W-1:0]     mem_waddr,
  output logic [HI_W+LO_W-1:0] mem_wdata
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [HI_W-1:0]  hold;
  logic             enter_rd;
  logic [IDX_W-1:0] base;
  logic [IDX_W-1:0] base_nxt;
  logic [IDX_W-1:0] idx_nxt;

  assign enter_rd  = wr_lo && wdata[CLR_B] && wdata[RDM_B];
  assign base      = wdata[CLR_B] ? '0 : idx;
  assign base_nxt  = (base == LAST) ? '0 : base + 1'b1;
  assign idx_nxt   = (idx == LAST) ? '0 : idx + 1'b1;

  assign mem_we    = wr_lo && !enter_rd;
  assign mem_waddr = base;
  assign mem_wdata = {hold, wdata[LO_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      hold    <= '0;
      rd_mode <= 1'b0;
    end else begin
      if (wr_hi) hold <= wdata[HI_W-1:0];
      if (wr_lo) begin
        if (enter_rd) begin
          rd_mode <= 1'b1;
          idx     <= '0;
        end else begin
          rd_mode <= 1'b0;
          idx     <= base_nxt;
        end
      end else if (rd_lo && rd_mode) begin
        idx <= idx_nxt;
      end
    end
  end

  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST); // R5
  AST_STORE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wdata[CLR_B] && idx == LAST) |=> (idx == '0)); // R5
  AST_INDEX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && wdata[CLR_B] && !wdata[RDM_B]) |=> (idx == IDX_W'(1))); // R4
  AST_READ_ENTER: assert property (@(posedge clk) disable iff (rst)
    enter_rd |=> (rd_mode && idx == '0)); // R6
  AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !wr_lo && rd_mode && idx != LAST) |=> (idx == $past(idx) + 1'b1)); // R6
  AST_READ_EXIT: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !enter_rd) |=> !rd_mode); // R7
  AST_IDLE_READ_STILL: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !wr_lo && !rd_mode) |=> $stable(idx)); // R7
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    !wr_hi |=> $stable(hold)); // R2
endmodule

// File: rtl/lut_cfg.sv
module lut_cfg #(
  parameter int BW    = 32,
  parameter int HUE_B = 29,
  parameter int SAT_B = 30,
  parameter int VAL_B = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_thr,
  input  logic          wr_mode,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] thresh,
  output logic          hue_en,
  output logic          sat_en,
  output logic          val_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      thresh <= '0;
      hue_en <= 1'b0;
      sat_en <= 1'b0;
      val_en <= 1'b0;
    end else begin
      if (wr_thr) thresh <= wdata;
      if (wr_mode) begin
        hue_en <= wdata[HUE_B];
        sat_en <= wdata[SAT_B];
        val_en <= wdata[VAL_B];
      end
    end
  end

  AST_THRESH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_thr |=> $stable(thresh)); // R8
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_mode |=> ($stable(hue_en) && $stable(sat_en) && $stable(val_en))); // R9
endmodule

// File: rtl/paired_lut_port.sv
module paired_lut_port
  import lut_pkg::*;
#(
  parameter int DEPTH = LUT_DEPTH,
  parameter int IDX_W = LUT_IDX_W,
  parameter int HI_W  = LUT_HI_W,
  parameter int LO_W  = LUT_LO_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [IDX_W-1:0]     lk_idx,
  output logic [HI_W+LO_W-1:0] lk_data,
  output logic                 hue_en,
  output logic                 sat_en,
  output logic                 val_en
);
  localparam int ENT_W = HI_W + LO_W;

  win_sel_e          sel;
  logic              aligned;
  logic              wr_lo, wr_hi, wr_thr, wr_mode, rd_lo;
  logic [IDX_W-1:0]  idx;
  logic              rd_mode;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_waddr;
  logic [ENT_W-1:0]  mem_wdata;
  logic [ENT_W-1:0]  ra_data;
  logic [BUS_W-1:0]  thresh;
  win_sel_e          rsel_q;
  logic              rmode_q;

  assign sel     = win_sel_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_lo   = bus_wr && aligned && sel == WIN_LO;
  assign wr_hi   = bus_wr && aligned && sel == WIN_HI;
  assign wr_thr  = bus_wr && aligned && sel == WIN_THR;
  assign wr_mode = bus_wr && aligned && sel == WIN_MODE;
  assign rd_lo   = bus_rd && !bus_wr && aligned && sel == WIN_LO;

  lut_seq #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .HI_W(HI_W), .LO_W(LO_W), .BW(BUS_W),
    .CLR_B(CTL_IDX_CLR), .RDM_B(CTL_RD_MODE)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo),
    .wdata(bus_wdata), .idx(idx), .rd_mode(rd_mode), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  lut_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W), .W(ENT_W)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .ra_addr(idx), .ra_data(ra_data), .lk_addr(lk_idx), .lk_data(lk_data)
  );

  lut_cfg #(
    .BW(BUS_W), .HUE_B(EN_HUE_BIT), .SAT_B(EN_SAT_BIT), .VAL_B(EN_VAL_BIT)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_thr(wr_thr), .wr_mode(wr_mode), .wdata(bus_wdata),
    .thresh(thresh), .hue_en(hue_en), .sat_en(sat_en), .val_en(val_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q  <= WIN_LO;
      rmode_q <= 1'b0;
    end else if (bus_rd && !bus_wr) begin
      rsel_q  <= sel;
      rmode_q <= rd_mode && aligned;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (rsel_q)
      WIN_LO:   if (rmode_q) bus_rdata[LO_W-1:0] = ra_data[LO_W-1:0];
      WIN_HI:   if (rmode_q) bus_rdata[HI_W-1:0] = ra_data[ENT_W-1:LO_W];
      WIN_THR:  bus_rdata = thresh;
      WIN_MODE: begin
        bus_rdata[EN_HUE_BIT] = hue_en;
        bus_rdata[EN_SAT_BIT] = sat_en;
        bus_rdata[EN_VAL_BIT] = val_en;
      end
      default:  bus_rdata = '0;
    endcase
  end

  AST_LO_READ_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (rsel_q == WIN_LO) |-> (bus_rdata[BUS_W-1:LO_W] == '0)); // R3
  AST_MODE_READ_MASK: assert property (@(posedge clk) disable iff (rst)
    (rsel_q == WIN_MODE) |-> (bus_rdata[EN_HUE_BIT-1:0] == '0)); // R9
endmodule

// File: tb/paired_lut_port_bench.sv
module paired_lut_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  lk_idx = '0;
  logic [43:0] lk_data;
  logic        hue_en, sat_en, val_en;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  paired_lut_port u_paired_lut_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_idx(lk_idx), .lk_data(lk_data),
    .hue_en(hue_en), .sat_en(sat_en), .val_en(val_en)
  );

  function automatic logic [31:0] hi_of(int i);
    logic [31:0] v = 32'(i);
    return (v * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [11:0] lo_of(int i);
    logic [31:0] v = 32'(i);
    return 12'((v * 37 + 5) & 32'hFFF);
  endfunction
  function automatic logic [31:0] junk_of(int i);
    logic [31:0] v = 32'(i);
    return ((v * 32'h0001_0103) << 12) & 32'hF9FF_F000;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic look(input logic [8:0] i, output logic [43:0] d);
    @(negedge clk);
    lk_idx = i;
    @(negedge clk);
    d = lk_data;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] r;
    logic [43:0] l;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'h8, r);  check("R1 thresh", 64'(r), 64'h0);
    rd(4'hC, r);  check("R1 mode", 64'(r), 64'h0);
    check("R1 enables", 64'({hue_en, sat_en, val_en}), 64'h0);
    rd(4'h0, r);  check("R1 lo idle", 64'(r), 64'h0);
    rd(4'h4, r);  check("R1 hi idle", 64'(r), 64'h0);

    // advance the index with throwaway stores, then load from an index clear (R4)
    for (int i = 0; i < 5; i++) begin
      wr(4'h4, 32'hFFFF_0000 | 32'(i));
      wr(4'h0, 32'h0000_0F00 | 32'(i));
    end
    for (int i = 0; i < 384; i++) begin
      wr(4'h4, hi_of(i));
      wr(4'h0, junk_of(i) | 32'(lo_of(i)) | ((i == 0) ? 32'h0400_0000 : 32'h0));
    end

    // R2 R3 R4 R10: sweep the lookup port over the full index range
    for (int i = 0; i < 512; i++) begin
      look(9'(i), l);
      if (i < 384) check("R2 R3 R4 lookup", 64'(l), 64'({hi_of(i), lo_of(i)}));
      else         check("R10 out of range", 64'(l), 64'h0);
    end

    // R6: read-back walk
    wr(4'h0, 32'h0600_0000);
    for (int i = 0; i < 384; i++) begin
      rd(4'h4, r); check("R6 hi read", 64'(r), 64'(hi_of(i)));
      rd(4'h0, r); check("R6 R3 lo read", 64'(r), 64'(lo_of(i)));
    end
    // R5: read index wrapped to 0; control write stored nothing at entry 0
    rd(4'h4, r); check("R5 read wrap", 64'(r), 64'(hi_of(0)));
    look(9'd0, l); check("R6 ctl no store", 64'(l), 64'({hi_of(0), lo_of(0)}));

    // R7: a plain store leaves read-back mode (index is 0 here)
    wr(4'h4, 32'hDEAD_0001);
    wr(4'h0, 32'h0000_00AB);
    rd(4'h0, r); check("R7 lo after exit", 64'(r), 64'h0);
    rd(4'h4, r); check("R7 hi after exit", 64'(r), 64'h0);
    look(9'd0, l); check("R2 store after exit", 64'(l), {20'h0, 32'hDEAD_0001, 12'h0AB});

    // R5: store wrap, index is 1; 384 stores end on entry 0
    for (int i = 1; i <= 384; i++) begin
      wr(4'h4, 32'hC000_0000 | 32'(i));
      wr(4'h0, 32'(i & 12'hFFF) ^ 32'h555);
    end
    look(9'd0, l);   check("R5 store wrap", 64'(l), 64'({32'hC000_0000 | 32'd384, 12'(32'd384 ^ 32'h555)}));
    look(9'd383, l); check("R5 last entry", 64'(l), 64'({32'hC000_0000 | 32'd383, 12'(32'd383 ^ 32'h555)}));
    look(9'd1, l);   check("R5 first entry", 64'(l), 64'({32'hC000_0001, 12'(32'd1 ^ 32'h555)}));

    // R8 threshold
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, r); check("R8 ones", 64'(r), 64'hFFFF_FFFF);
    wr(4'h8, 32'hA5A5_5A5A); rd(4'h8, r); check("R8 pattern", 64'(r), 64'hA5A5_5A5A);
    wr(4'h8, 32'h0);         rd(4'h8, r); check("R8 zero", 64'(r), 64'h0);

    // R9 operating-mode enables
    for (int b = 0; b < 8; b++) begin
      wr(4'hC, (32'(b) << 29) | 32'h1234_5678 & 32'h1FFF_FFFF);
      check("R9 enables", 64'({val_en, sat_en, hue_en}), 64'(b));
      rd(4'hC, r); check("R9 mode read", 64'(r), 64'(32'(b) << 29));
    end

    finish_run();
  end
endmodule